// File: doc/BRIEF.md
# Transmit Status Word Builder

This block follows one Ethernet frame from the moment it is queued for transmission until the MAC reports that it has finished. It records three things about the attempt: whether the frame had to wait for a busy medium, how many collisions it met, and whether it hit one of two limits that end the frame early. It then packs that record into a 32-bit status word for a status FIFO.

The frame's life has two phases. In the waiting phase, a deferral timer counts bit-time ticks while the medium is busy. The transmit-start pulse moves the frame into the transmitting phase, where collisions are counted. The frame ends in one of three ways:
- the MAC raises transmit-done or abort;
- the sixteenth collision arrives;
- the deferral timer passes its limit while the check is enabled.

Whichever way it ends, the word is registered and marked by a one-cycle valid strobe. All per-frame state is then cleared for the next frame.

The status output is a plain one-cycle valid strobe with no ready input, so there is no back-pressure. The status FIFO must accept a word in every cycle that valid is high.

Top module: `tx_status_builder`

## Requirements
- R1: After reset, `sts_valid` is low and `sts_word` is all zeros until the first frame ends.
- R2: Bit 0 of the word is 1 when `medium_busy` was high in at least one cycle of the waiting phase, counting from the previous frame end up to the cycle before the terminating cycle. Otherwise bit 0 is 0.
- R3: Bits 6:3 hold the number of cycles with `collision` high during the transmitting phase. Collisions seen in the waiting phase are not counted.
- R4: On the sixteenth collision of a frame, without any done or abort, a word is emitted in the next cycle. That word has bit 8 set and the count field saturated at 15.
- R5: With `defer_chk_en` high, a tick with `medium_busy` high in the waiting phase ends the frame when the timer already holds DEFER_LIMIT; that is, on tick number DEFER_LIMIT+1. The resulting word has bits 2 and 0 set. With `defer_chk_en` low, deferral never ends a frame and bit 2 stays 0.
- R6: Bits 1 and 7 are always 0, as are bits 31:16 and 14:9.
- R7: Bit 15 equals the OR of bit 8 and bit 2.
- R8: A word appears with `sts_valid` high for exactly one cycle, in the cycle after `tx_done` or `tx_abort` is sampled high. The flags, the timer and the collision count then restart from zero.
- R9: `medium_busy` and `bit_tick` during the transmitting phase neither set bit 0 nor advance the deferral timer.
- R10: When `tx_done` or `tx_abort` coincides with a collision, a tick or `medium_busy`, the word reflects the state before that cycle. Priority is: done/abort, then deferral limit, then the sixteenth collision, then `tx_start`. A `tx_start` while already transmitting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| medium_busy | input | 1 | Carrier sensed / MAC is deferring |
| collision | input | 1 | One cycle per collision |
| tx_start | input | 1 | First transmit attempt begins |
| tx_done | input | 1 | MAC finished the frame |
| tx_abort | input | 1 | MAC abandoned the frame |
| defer_chk_en | input | 1 | Enables the excessive-deferral limit |
| sts_valid | output | 1 | One-cycle strobe, word is valid |
| sts_word | output | 32 | Packed status word |

## Verification
The bench builds the block with DEFER_LIMIT set to 20 instead of 24288. This puts the excessive-deferral trip, and the saturation of the timer when the check is disabled, within a few dozen cycles. The collision field keeps its fixed 4-bit width, so the sixteenth-collision abort is reached with the real count. Same-cycle coincidences of done with collisions and ticks are driven on purpose to exercise the priority order.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int STS_W    = 32;
  localparam int COLL_W   = 4;
  localparam int COLL_MAX = (1 << COLL_W) - 1;

  localparam int B_DEFERRED = 0;
  localparam int B_XDEFER   = 2;
  localparam int B_CNT_LO   = 3;
  localparam int B_XCOLL    = 8;
  localparam int B_ERRSUM   = 15;

  function automatic logic [STS_W-1:0] pack_status(
    input logic              deferred,
    input logic              xdefer,
    input logic [COLL_W-1:0] cnt,
    input logic              xcoll
  );
    logic [STS_W-1:0] w;
    w = '0;
    w[B_DEFERRED]                 = deferred;
    w[B_XDEFER]                   = xdefer;
    w[B_CNT_LO +: COLL_W]         = cnt;
    w[B_XCOLL]                    = xcoll;
    w[B_ERRSUM]                   = xdefer | xcoll;
    return w;
  endfunction
endpackage

// File: rtl/tsw_defer_timer.sv
module tsw_defer_timer #(
  parameter int DEFER_LIMIT = 24288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_phase,
  input  logic medium_busy,
  input  logic bit_tick,
  input  logic chk_en,
  input  logic clr_tmr,
  input  logic clr_frame,
  output logic trip,
  output logic deferred
);
  localparam int TMR_W = $clog2(DEFER_LIMIT + 1);
  localparam logic [TMR_W-1:0] LIM = TMR_W'(DEFER_LIMIT);

  logic [TMR_W-1:0] tmr_q;
  logic             busy_tick;

  assign busy_tick = wait_phase & medium_busy & bit_tick;
  assign trip      = busy_tick & chk_en & (tmr_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_frame || clr_tmr) begin
      tmr_q <= '0;
    end else if (busy_tick && tmr_q != LIM) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_frame) begin
      deferred <= 1'b0;
    end else if (wait_phase && medium_busy) begin
      deferred <= 1'b1;
    end
  end
endmodule

// File: rtl/tsw_coll_counter.sv
module tsw_coll_counter
  import tsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              clr,
  output logic [COLL_W-1:0] cnt,
  output logic              trip
);
  localparam logic [COLL_W-1:0] MAXV = COLL_W'(COLL_MAX);

  assign trip = hit & (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (hit && cnt != MAXV) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tx_status_builder.sv
module tx_status_builder
  import tsw_pkg::*;
#(
  parameter int DEFER_LIMIT = 24288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             medium_busy,
  input  logic             collision,
  input  logic             tx_start,
  input  logic             tx_done,
  input  logic             tx_abort,
  input  logic             defer_chk_en,
  output logic             sts_valid,
  output logic [STS_W-1:0] sts_word
);
  logic              in_tx;
  logic              ev_ext, d_trip, c_trip, d_end, c_end, finish, go;
  logic              deferred;
  logic [COLL_W-1:0] cnt;

  assign ev_ext = tx_done | tx_abort;
  assign d_end  = d_trip & ~ev_ext;
  assign c_end  = c_trip & ~ev_ext & ~d_end;
  assign finish = ev_ext | d_end | c_end;
  assign go     = tx_start & ~in_tx & ~finish;

  tsw_defer_timer #(.DEFER_LIMIT(DEFER_LIMIT)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_phase (~in_tx),
    .medium_busy(medium_busy),
    .bit_tick   (bit_tick),
    .chk_en     (defer_chk_en),
    .clr_tmr    (go),
    .clr_frame  (finish),
    .trip       (d_trip),
    .deferred   (deferred)
  );

  tsw_coll_counter u_coll (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (in_tx & collision),
    .clr  (finish),
    .cnt  (cnt),
    .trip (c_trip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tx     <= 1'b0;
      sts_valid <= 1'b0;
      sts_word  <= '0;
    end else begin
      sts_valid <= finish;
      if (ev_ext) begin
        sts_word <= pack_status(deferred, 1'b0, cnt, 1'b0);
      end else if (d_end) begin
        sts_word <= pack_status(1'b1, 1'b1, cnt, 1'b0);
      end else if (c_end) begin
        sts_word <= pack_status(deferred, 1'b0, cnt, 1'b1);
      end
      if (finish) begin
        in_tx <= 1'b0;
      end else if (go) begin
        in_tx <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_done,
  input logic        tx_abort,
  input logic        collision,
  input logic        bit_tick,
  input logic        defer_chk_en,
  input logic        sts_valid,
  input logic [31:0] sts_word
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> (sts_word[1] == 1'b0 && sts_word[7] == 1'b0 && sts_word[31:16] == '0)); // R6
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> (sts_word[15] == (sts_word[8] | sts_word[2]))); // R7
  AST_XCOLL_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && sts_word[8]) |-> (sts_word[6:3] == 4'hF)); // R4
  AST_XDEFER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && sts_word[2]) |-> ($past(defer_chk_en) && sts_word[0])); // R5
  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_valid) |-> $past(tx_done || tx_abort || collision || bit_tick)); // R8
  AST_DONE_GIVES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || tx_abort) |=> sts_valid); // R8
endmodule

bind tx_status_builder tsw_checker u_tsw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_done     (tx_done),
  .tx_abort    (tx_abort),
  .collision   (collision),
  .bit_tick    (bit_tick),
  .defer_chk_en(defer_chk_en),
  .sts_valid   (sts_valid),
  .sts_word    (sts_word)
);

// File: tb/tx_status_builder_bench.sv
`timescale 1ns/1ps
module tx_status_builder_bench;
  localparam int LIM = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, medium_busy = 0, collision = 0;
  logic tx_start = 0, tx_done = 0, tx_abort = 0, defer_chk_en = 0;
  logic        sts_valid;
  logic [31:0] sts_word;

  int n_chk = 0, n_fail = 0;
  logic [31:0] last_word = '0;
  int n_words = 0;

  // reference model state
  bit m_in_tx, m_def, m_valid;
  int m_tmr, m_cnt;
  logic [31:0] m_word;

  always #2.5 clk = ~clk;

  tx_status_builder #(.DEFER_LIMIT(LIM)) u_tx_status_builder (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .medium_busy(medium_busy),
    .collision(collision), .tx_start(tx_start), .tx_done(tx_done),
    .tx_abort(tx_abort), .defer_chk_en(defer_chk_en),
    .sts_valid(sts_valid), .sts_word(sts_word)
  );

  function automatic logic [31:0] mk(bit d, bit xd, int c, bit xc);
    logic [31:0] w = '0;
    w[0] = d; w[2] = xd; w[6:3] = c[3:0]; w[8] = xc; w[15] = xd | xc;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in_tx = 0; m_def = 0; m_valid = 0; m_tmr = 0; m_cnt = 0; m_word = '0;
    end else begin
      m_valid = 0;
      if (tx_done || tx_abort) begin
        m_word = mk(m_def, 0, m_cnt, 0); m_valid = 1;
      end else if (!m_in_tx && medium_busy && bit_tick && defer_chk_en && m_tmr == LIM) begin
        m_word = mk(1, 1, m_cnt, 0); m_valid = 1;
      end else if (m_in_tx && collision && m_cnt == 15) begin
        m_word = mk(m_def, 0, 15, 1); m_valid = 1;
      end else if (!m_in_tx) begin
        if (medium_busy) m_def = 1;
        if (medium_busy && bit_tick && m_tmr < LIM) m_tmr++;
        if (tx_start) begin m_in_tx = 1; m_tmr = 0; end
      end else if (collision) begin
        m_cnt++;
      end
      if (m_valid) begin m_in_tx = 0; m_def = 0; m_tmr = 0; m_cnt = 0; end
    end
  end

  // per-cycle comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 valid strobe", {31'b0, sts_valid}, {31'b0, m_valid});
      chk("R2 R3 R4 R5 R6 R7 word", sts_word, m_word);
      if (sts_valid) begin last_word = sts_word; n_words++; end
    end
  end

  task automatic cyc(bit b, bit t, bit c, bit s, bit d, bit a);
    @(negedge clk);
    medium_busy = b; bit_tick = t; collision = c; tx_start = s; tx_done = d; tx_abort = a;
    @(negedge clk);
    medium_busy = 0; bit_tick = 0; collision = 0; tx_start = 0; tx_done = 0; tx_abort = 0;
  endtask

  // last_word is updated at the negedge after the word appears
  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin : wdog
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, sts_valid}, 32'd0);
    chk("R1 reset word", sts_word, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {31'b0, sts_valid}, 32'd0);

    // clean frame
    cyc(0,0,0,1,0,0); cyc(0,0,0,0,0,0); cyc(0,0,0,0,1,0); settle();
    chk("R8 clean frame word", last_word, 32'h0);

    // deferred, two collisions
    for (int i = 0; i < 5; i++) cyc(1,1,0,0,0,0);
    cyc(0,0,0,1,0,0); cyc(0,0,1,0,0,0); cyc(0,0,1,0,0,0); cyc(0,0,0,0,1,0); settle();
    chk("R2 R3 deferred with 2 collisions", last_word, mk(1,0,2,0));

    // collisions before start ignored, abort path
    cyc(0,0,1,0,0,0); cyc(0,0,1,0,0,0); cyc(0,0,0,1,0,0); cyc(0,0,1,0,0,0); cyc(0,0,0,0,0,1); settle();
    chk("R3 pre-start collisions ignored", last_word, mk(0,0,1,0));

    // sixteen collisions end the frame
    cyc(0,0,0,1,0,0);
    w0 = n_words;
    for (int i = 0; i < 16; i++) cyc(0,0,1,0,0,0);
    settle();
    chk("R4 sixteenth collision emits word", n_words - w0, 1);
    chk("R4 R7 excessive collision word", last_word, mk(0,0,15,1));

    // excessive deferral with check enabled
    defer_chk_en = 1;
    w0 = n_words;
    for (int i = 0; i < LIM; i++) cyc(1,1,0,0,0,0);
    chk("R5 no trip at limit", n_words - w0, 0);
    cyc(1,1,0,0,0,0); settle();
    chk("R5 trip past limit", n_words - w0, 1);
    chk("R5 R7 excessive deferral word", last_word, mk(1,1,0,0));

    // check disabled: no trip
    defer_chk_en = 0;
    w0 = n_words;
    for (int i = 0; i < LIM + 10; i++) cyc(1,1,0,0,0,0);
    chk("R5 disabled never trips", n_words - w0, 0);
    cyc(0,0,0,1,0,0); cyc(0,0,0,0,1,0); settle();
    chk("R5 disabled word", last_word, mk(1,0,0,0));

    // busy during transmission ignored
    defer_chk_en = 1;
    cyc(0,0,0,1,0,0);
    for (int i = 0; i < LIM + 5; i++) cyc(1,1,0,0,0,0);
    cyc(0,0,0,0,1,0); settle();
    chk("R9 busy in transmit ignored", last_word, 32'h0);

    // coincidences: collision with done, second start ignored
    cyc(0,0,0,1,0,0); cyc(0,0,1,0,0,0); cyc(0,0,0,1,0,0); cyc(0,0,1,0,1,0); settle();
    chk("R10 same-cycle collision excluded", last_word, mk(0,0,1,0));
    cyc(1,1,0,0,1,0); settle();
    chk("R10 busy with done excluded", last_word, 32'h0);
    chk("R6 reserved bits zero", last_word & 32'hFFFF_7E82, 32'h0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule